// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog timer whose control register guards its critical fields behind a short unlock window. Software reads and writes an 8-bit control register through a plain register port. It restarts the timeout with a one-cycle kick strobe. A separate slow watchdog oscillator is modelled as a tick enable on the system clock. If the counter of enabled ticks reaches the selected timeout with no kick in between, the block raises a one-clock reset pulse and starts counting again.

Two static configuration inputs stand in for one-time fuses and pick one of three protection levels. Level 0 is the lax setting: the timeout select can be rewritten at any time, and turning the timer off needs the unlock window. Level 1 also guards the timeout select behind the window. Level 2 also guards the timeout select, and the timer runs from reset and can never be stopped.

The unlock window is the state machine `WIN_SHUT`/`WIN_OPEN`. A write with the change-enable bit set (arm) moves `WIN_SHUT -> WIN_OPEN`, and a new arm while open restarts the window (`WIN_OPEN -> WIN_OPEN`). After four cycles with no arm it returns `WIN_OPEN -> WIN_SHUT`. The timeout counter is the state machine `TMR_IDLE`/`TMR_COUNT`/`TMR_BITE`:
- Enable raised: `TMR_IDLE -> TMR_COUNT`.
- Terminal count reached on a tick: `TMR_COUNT -> TMR_BITE`.
- After one cycle: `TMR_BITE -> TMR_COUNT`.
- Enable dropped: any state `-> TMR_IDLE`.

Top module: `wdt_guard`

## Requirements
- R1: The register reads as {3'b000, change-enable at bit 4, enable at bit 3, timeout select at bits 2:0}. Bits 7:5 always read 0. After reset the register reads 0x00 in levels 0 and 1.
- R2: After a write with bit 4 set, bit 4 reads 1 for exactly four cycles and then clears by itself.
- R3: A write with bit 3 = 0 while bit 4 reads 0 leaves the timer enabled. This includes a write made after the window has expired.
- R4: A write with bit 3 = 1 enables the timer at any time. A write with bit 3 = 0 while bit 4 reads 1 disables it in levels 0 and 1.
- R5: Level decode, where 1 means programmed: cfg_always_on = 1 gives level 2; cfg_compat = 1 with cfg_always_on = 0 gives level 0; both 0 gives level 1.
- R6: In level 2, bit 3 reads 1 from reset onward. No write sequence stops the timeout, including the full unlock sequence.
- R7: In level 0, every write loads bits 2:0. In levels 1 and 2, bits 2:0 load only while bit 4 reads 1; otherwise they keep their value.
- R8: With select n, the reset pulse rises exactly 2^(BASE_EXP+n) ticks after the last kick, and lasts one cycle.
- R9: A kick clears the counter and suppresses the pulse in the following cycle. Cycles without a tick do not advance the count, and regular kicks keep the pulse from ever firing.
- R10: A further write with bit 4 set while the window is open restarts the four-cycle window from that write.
- R11: While the timer is disabled, no reset pulse is produced however many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_compat | input | 1 | Static compatibility configuration bit (1 = programmed) |
| cfg_always_on | input | 1 | Static always-on configuration bit (1 = programmed) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| kick | input | 1 | Watchdog restart strobe |
| tick_en | input | 1 | Watchdog oscillator tick, one clock wide |
| wdt_rst | output | 1 | One-cycle system reset request |

## Verification
The bench builds the design with a base exponent of 2 and sweeps all eight timeout selects under all four configuration-input pairs. Each measured interval is compared with 4·2^n ticks, which separates a wrong shift, an off-by-one terminal count and a wrong select decode. Writes that clear bit 3 are issued in three situations: with the window shut, after it has just expired, and inside it. These tell the lock rule apart from the unlock rule, and each level apart from the others. Stalled ticks, periodic kicks and a restarted window expose counters that advance on the wrong qualifier or a window that ignores a second arm.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    // Protection level chosen by the static configuration inputs
    typedef enum logic [1:0] {
        LVL_0 = 2'd0,
        LVL_1 = 2'd1,
        LVL_2 = 2'd2
    } safety_t;

    // Unlock window states
    typedef enum logic {
        WIN_SHUT = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_t;

    // Timeout counter states
    typedef enum logic [1:0] {
        TMR_IDLE  = 2'd0,
        TMR_COUNT = 2'd1,
        TMR_BITE  = 2'd2
    } tmr_state_t;

    // Control register geometry
    localparam int CTRL_W = 8;
    localparam int PS_W   = 3;
    localparam int BIT_CE = 4;
    localparam int BIT_EN = 3;

endpackage

// File: rtl/wdt_level_decode.sv
module wdt_level_decode
    import wdt_guard_pkg::*;
(
    input  logic    cfg_compat,
    input  logic    cfg_always_on,
    output safety_t level
);

    // The always-on input dominates; compatibility only relaxes level 1
    always_comb begin
        unique case ({cfg_always_on, cfg_compat})
            2'b00:   level = LVL_1;
            2'b01:   level = LVL_0;
            default: level = LVL_2;
        endcase
    end

endmodule

// File: rtl/wdt_change_window.sv
module wdt_change_window
    import wdt_guard_pkg::*;
#(
    parameter int WIN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic open
);

    localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;

    win_state_t     state_q, state_nx;
    logic [CW-1:0]  left_q, left_nx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIN_SHUT;
            left_q  <= '0;
        end else begin
            state_q <= state_nx;
            left_q  <= left_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        left_nx  = left_q;
        unique case (state_q)
            WIN_SHUT: begin
                if (arm) begin
                    state_nx = WIN_OPEN;
                    left_nx  = CW'(WIN_CYC - 1);
                end
            end
            WIN_OPEN: begin
                if (arm) begin
                    left_nx = CW'(WIN_CYC - 1);
                end else if (left_q == '0) begin
                    state_nx = WIN_SHUT;
                end else begin
                    left_nx = left_q - 1'b1;
                end
            end
            default: begin
                state_nx = WIN_SHUT;
                left_nx  = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        open = (state_q == WIN_OPEN);
    end

    // Independent run-length tracker for the window check
    logic [7:0] chk_run;
    always_ff @(posedge clk) begin
        if (!rst_n)      chk_run <= 8'd0;
        else if (arm)    chk_run <= 8'd1;
        else if (open)   chk_run <= chk_run + 8'd1;
        else             chk_run <= 8'd0;
    end

    // R2
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open |-> (chk_run <= 8'(WIN_CYC)));

    // R2
    window_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> open);

endmodule

// File: rtl/wdt_timeout_ctr.sv
module wdt_timeout_ctr
    import wdt_guard_pkg::*;
#(
    parameter int BASE_EXP = 14,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             kick,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             bite
);

    localparam int NSEL  = 1 << SEL_W;
    localparam int CNT_W = BASE_EXP + NSEL - 1;

    tmr_state_t        state_q, state_nx;
    logic [CNT_W-1:0]  cnt_q, cnt_nx;
    logic [CNT_W-1:0]  term [NSEL];
    logic              hit;

    // Terminal counts: 2^(BASE_EXP+g) - 1 for every select value
    for (genvar g = 0; g < NSEL; g++) begin : g_term
        assign term[g] = {CNT_W{1'b1}} >> (NSEL - 1 - g);
    end

    assign hit = tick && (cnt_q >= term[sel]);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        unique case (state_q)
            TMR_IDLE: begin
                cnt_nx = '0;
                if (run) state_nx = TMR_COUNT;
            end
            TMR_COUNT: begin
                if (!run) begin
                    state_nx = TMR_IDLE;
                    cnt_nx   = '0;
                end else if (kick) begin
                    cnt_nx = '0;
                end else if (hit) begin
                    state_nx = TMR_BITE;
                    cnt_nx   = '0;
                end else if (tick) begin
                    cnt_nx = cnt_q + 1'b1;
                end
            end
            TMR_BITE: begin
                if (!run) begin
                    state_nx = TMR_IDLE;
                    cnt_nx   = '0;
                end else begin
                    state_nx = TMR_COUNT;
                    cnt_nx   = (tick && !kick) ? CNT_W'(1) : '0;
                end
            end
            default: begin
                state_nx = TMR_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        bite = (state_q == TMR_BITE);
    end

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bite |=> !bite);

    // R9
    kick_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !bite);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_COUNT && run && !tick && !kick) |=> $stable(cnt_q));

    // R11
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !bite);

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int BASE_EXP = 14,
    parameter int WIN_CYC  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_compat,
    input  logic        cfg_always_on,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    input  logic        kick,
    input  logic        tick_en,
    output logic        wdt_rst
);

    safety_t          level;
    logic             ce_open;
    logic             arm;
    logic             en_q;
    logic [PS_W-1:0]  sel_q;
    logic             eff_en;
    logic             unused_rsvd_bits;

    assign unused_rsvd_bits = ^wr_data[CTRL_W-1:BIT_CE+1];

    wdt_level_decode u_level (
        .cfg_compat    (cfg_compat),
        .cfg_always_on (cfg_always_on),
        .level         (level)
    );

    assign arm = wr_en && wr_data[BIT_CE];

    wdt_change_window #(.WIN_CYC(WIN_CYC)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .open  (ce_open)
    );

    // Guarded enable and timeout select; the window state is sampled before the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= '0;
        end else if (wr_en) begin
            if (wr_data[BIT_EN])  en_q <= 1'b1;
            else if (ce_open)     en_q <= 1'b0;
            if (level == LVL_0 || ce_open)
                sel_q <= wr_data[PS_W-1:0];
        end
    end

    assign eff_en = en_q || (level == LVL_2);

    always_comb begin
        rd_data         = '0;
        rd_data[BIT_CE] = ce_open;
        rd_data[BIT_EN] = eff_en;
        rd_data[PS_W-1:0] = sel_q;
    end

    wdt_timeout_ctr #(.BASE_EXP(BASE_EXP), .SEL_W(PS_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (eff_en),
        .kick  (kick),
        .tick  (tick_en),
        .sel   (sel_q),
        .bite  (wdt_rst)
    );

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:5] == 3'b000);

    // R3
    lock_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[BIT_EN] && !rd_data[BIT_CE] && rd_data[BIT_EN]) |=> rd_data[BIT_EN]);

    // R4
    set_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[BIT_EN]) |=> rd_data[BIT_EN]);

    // R6
    lvl2_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LVL_2) |-> rd_data[BIT_EN]);

    // R7
    sel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_data[BIT_CE] && level != LVL_0) |=> $stable(rd_data[PS_W-1:0]));

    // R8
    rst_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> $past(rd_data[BIT_EN]));

endmodule

// File: tb/wdt_guard_test.sv
`timescale 1ns/1ps
module wdt_guard_test;

    localparam int BASE = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_compat = 1'b0;
    logic       cfg_always_on = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       kick = 1'b0;
    logic       tick_en = 1'b0;
    logic       wdt_rst;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdt_guard #(.BASE_EXP(BASE), .WIN_CYC(4)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_compat    (cfg_compat),
        .cfg_always_on (cfg_always_on),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rd_data       (rd_data),
        .kick          (kick),
        .tick_en       (tick_en),
        .wdt_rst       (wdt_rst)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; kick = 1'b0; tick_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Write at one edge; returns at the negedge after it
    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Kick, optionally stall ticks, then count ticks until the reset pulse
    task automatic measure(input int exp_n, input string req, input int stall);
        int n;
        int early;
        early = 0;
        @(negedge clk);
        kick = 1'b1; tick_en = (stall == 0);
        @(posedge clk);
        @(negedge clk);
        kick = 1'b0;
        for (int s = 0; s < stall; s++) begin
            if (wdt_rst) early++;
            @(negedge clk);
        end
        if (stall > 0) chk(early == 0, req, early, 0);
        tick_en = 1'b1;
        n = 0;
        while (n < 4000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (wdt_rst) break;
        end
        chk(n == exp_n, req, n, exp_n);
        @(negedge clk);
        chk(wdt_rst == 1'b0, "R8 pulse width", int'(wdt_rst), 0);
        tick_en = 1'b0;
    endtask

    // Count reset pulses over a run of ticks, optionally kicking periodically
    task automatic quiet(input int cycles, input int kick_every, input string req);
        int seen;
        seen = 0;
        @(negedge clk);
        tick_en = 1'b1;
        for (int c = 0; c < cycles; c++) begin
            kick = (kick_every > 0) && (c % kick_every == 0);
            @(negedge clk);
            if (wdt_rst) seen++;
        end
        kick = 1'b0;
        tick_en = 1'b0;
        chk(seen == 0, req, seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            bit lvl0, lvl2;
            cfg_compat    = c[0];
            cfg_always_on = c[1];
            lvl2 = cfg_always_on;
            lvl0 = cfg_compat && !cfg_always_on;
            do_reset();

            // R1 R5 R6: reset value per level
            chk(rd_data == (lvl2 ? 8'h08 : 8'h00), "R1 R5 reset value",
                int'(rd_data), lvl2 ? 8 : 0);

            if (!lvl0 && !lvl2) begin
                // R2: four-cycle window
                wr(8'h10);
                for (int k = 0; k < 6; k++) begin
                    chk(rd_data[4] == (k < 4), "R2 window", int'(rd_data[4]), int'(k < 4));
                    @(negedge clk);
                end
                // R10: second arm restarts window
                wr(8'h10);
                idle(1);
                wr(8'h10);
                for (int k = 0; k < 5; k++) begin
                    chk(rd_data[4] == (k < 4), "R10 restart", int'(rd_data[4]), int'(k < 4));
                    @(negedge clk);
                end
            end

            // Timeout select sweep
            for (int ps = 0; ps < 8; ps++) begin
                idle(5);
                if (lvl0) begin
                    wr(8'h08 | 8'(ps));
                    chk(rd_data[2:0] == 3'(ps), "R7 free select", int'(rd_data[2:0]), ps);
                end else begin
                    logic [2:0] prev;
                    prev = rd_data[2:0];
                    wr(8'h08 | 8'(~ps & 7));
                    chk(rd_data[2:0] == prev, "R7 locked select", int'(rd_data[2:0]), int'(prev));
                    wr(8'h18);
                    wr(8'h08 | 8'(ps));
                    chk(rd_data[2:0] == 3'(ps), "R7 unlocked select", int'(rd_data[2:0]), ps);
                end
                chk(rd_data[3] == 1'b1, "R4 enable", int'(rd_data[3]), 1);
                measure(4 << ps, "R8 timeout", 0);
            end

            // R3: clearing enable with window shut
            idle(5);
            wr(8'h07);
            chk(rd_data[3] == 1'b1, "R3 locked disable", int'(rd_data[3]), 1);

            // R3: clearing enable just after window expiry
            wr(8'h1F);
            idle(4);
            chk(rd_data[4] == 1'b0, "R2 expiry", int'(rd_data[4]), 0);
            wr(8'h07);
            chk(rd_data[3] == 1'b1, "R3 expired disable", int'(rd_data[3]), 1);

            // R4 / R6: timed disable sequence
            wr(8'h1F);
            wr(8'h07);
            if (lvl2) begin
                chk(rd_data[3] == 1'b1, "R6 no disable", int'(rd_data[3]), 1);
                measure(4 << 7, "R6 still times out", 0);
            end else begin
                chk(rd_data[3] == 1'b0, "R4 timed disable", int'(rd_data[3]), 0);
                quiet(600, 0, "R11 disabled quiet");
                wr(8'h0F);
                chk(rd_data[3] == 1'b1, "R4 re-enable", int'(rd_data[3]), 1);
            end

            if (!lvl0 && !lvl2) begin
                // R9: stalled ticks do not advance; regular kicks hold off reset
                measure(4 << 7, "R9 stall", 30);
                quiet(1500, 100, "R9 periodic kick");
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule